// File: doc/BRIEF.md
# Byte-Granular Output Unstaging Reader

This block sits between a first-word-fall-through output queue of 64-bit words and a host bus that reads narrower pieces. The host reads one byte, four bytes or the whole eight-byte word at a time. Any address in the read window reaches the same queue head, and only the low address bits pick the byte lanes. The block records which lanes of the current head word the host has taken. When the last untaken lane is read, the block pops the queue so that the next word becomes visible.

Reading a lane a second time before the word has been popped is refused and flagged as an error. A read while the queue is empty is also flagged. Read data comes back one clock after the request, in the lanes the request selected. The queue storage and whatever fills it are outside this block.

Top module: `byte_unstage_reader`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after reset until the first read, `rd_valid`, `err_dup` and `err_underflow` are 0, `rd_data` is zero, and no lane counts as taken.
- R2: A read request (`rd_en` high) is answered one cycle later with `rd_valid` high. Selected lanes carry the head word's bytes in their own lane positions: byte k is bits 8k+7..8k. All other lanes are zero.
- R3: Lane selection uses `rd_size`. Code 0 reads one byte at lane `rd_addr[2:0]`. Code 1 reads four bytes: lanes 0–3 when `rd_addr[2]` is 0 and lanes 4–7 when it is 1. Code 2 reads all eight lanes. Address bits above bit 2 have no effect.
- R4: Accepted reads accumulate the lanes they take. In the request cycle of the read that completes all eight lanes, `fifo_pop` is high for that one cycle. The taken-lane record clears at that edge, so the next word starts fresh.
- R5: An eight-byte read of a word with no lanes yet taken pops it at the same clock edge that registers the returned data.
- R6: A read that selects any lane already taken from the current word returns zero data with `err_dup` high for that response cycle. It does not pop and does not change the taken-lane record.
- R7: A read while `fifo_empty` is high returns zero data with `err_underflow` high for that response cycle. It does not pop and does not change the taken-lane record.
- R8: `fifo_pop` is high only in a cycle with `rd_en` high and `fifo_empty` low. In a cycle after no request, `rd_valid` and both error flags are low.
- R9: `rd_size` code 3 behaves exactly like code 2 (whole word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read request for this cycle |
| rd_addr | input | ADDR_W (12) | Read address; bits 2..0 select lanes |
| rd_size | input | 2 | Read width code: 0 = 1 byte, 1 = 4 bytes, 2 or 3 = 8 bytes |
| fifo_empty | input | 1 | Output queue holds no word |
| fifo_head | input | 64 | Word at the queue head |
| fifo_pop | output | 1 | Remove the head word at this clock edge |
| rd_valid | output | 1 | Response cycle for the previous request |
| rd_data | output | 64 | Returned lanes, unselected lanes zero |
| err_dup | output | 1 | Previous request re-read a taken lane |
| err_underflow | output | 1 | Previous request found the queue empty |

## Verification
On every cycle, the assertions check the relation between requests and responses: one response per request, at most one error flag, zero data on any error, and pops only when a request meets a non-empty queue. They also check that a refused read leaves the taken-lane record unchanged and that a pop clears it. The bench's scenarios are what show that the returned bytes land in the correct lanes for each width and address, including high address bits that must be ignored. The bench also shows that the pop falls on exactly the read completing the eighth lane, however the reads are ordered, and that a refused read does not delay the pop of a word read afterwards.

// File: rtl/byte_unstage_pkg.sv
// Shared types for the byte-granular output unstaging reader.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package byte_unstage_pkg;

    // Read width code as it arrives on the bus.
    typedef enum logic [1:0] {
        SZ_ONE   = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WHOLE = 2'd2,
        SZ_SPARE = 2'd3
    } rd_size_e;

    // Classification of the request seen in the current cycle.
    typedef enum logic [1:0] {
        OC_IDLE  = 2'd0,
        OC_DATA  = 2'd1,
        OC_DUP   = 2'd2,
        OC_UNDER = 2'd3
    } outcome_e;

endpackage

// File: rtl/bur_lane_decode.sv
// Turns the read width code and the low address bits into a lane mask.
// Assumes: WORD_BYTES and MID_BYTES are powers of two, MID_BYTES <= WORD_BYTES.
// Address bits above the lane index are not used: every address in the
// window reaches the same queue head.
module bur_lane_decode
    import byte_unstage_pkg::*;
#(
    parameter int WORD_BYTES = 8,
    parameter int MID_BYTES  = 4,
    parameter int ADDR_W     = 12
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0]            size,
    output logic [WORD_BYTES-1:0] sel_mask
);

    localparam int LANE_W = $clog2(WORD_BYTES);
    localparam logic [LANE_W-1:0] MID_ALIGN = LANE_W'(MID_BYTES - 1);

    logic [LANE_W-1:0]     lane;
    logic [LANE_W-1:0]     mid_base;
    logic [WORD_BYTES-1:0] one_hit;
    logic [WORD_BYTES-1:0] mid_hit;
    logic                  unused_high_addr;
    rd_size_e              size_code;

    // Pick the lane index and the aligned base of a mid-width read.
    always_comb begin
        lane      = addr[LANE_W-1:0];
        mid_base  = lane & ~MID_ALIGN;
        size_code = rd_size_e'(size);
    end

    // Upper address bits are deliberately ignored.
    assign unused_high_addr = ^addr[ADDR_W-1:LANE_W];

    // One comparator pair per lane.
    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        assign one_hit[i] = (lane == LANE_W'(i));
        assign mid_hit[i] = (mid_base == (LANE_W'(i) & ~MID_ALIGN));
    end

    // Choose the mask that matches the width code; both wide codes take all lanes.
    always_comb begin
        unique case (size_code)
            SZ_ONE:  sel_mask = one_hit;
            SZ_HALF: sel_mask = mid_hit;
            default: sel_mask = '1;
        endcase
    end

endmodule

// File: rtl/bur_consume_tracker.sv
// Keeps the record of lanes already taken from the current head word,
// classifies each request and raises the pop on the completing read.
// Assumes: the queue head is valid whenever the empty flag is low, and the
// queue removes its head at the clock edge where pop is high.
module bur_consume_tracker
    import byte_unstage_pkg::*;
#(
    parameter int WORD_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  empty,
    input  logic [WORD_BYTES-1:0] sel_mask,
    output outcome_e              outcome,
    output logic                  pop
);

    logic [WORD_BYTES-1:0] taken_q;
    logic [WORD_BYTES-1:0] merged;
    logic                  overlap;
    logic                  complete;

    // Compare the request with the lanes already taken.
    always_comb begin
        merged   = taken_q | sel_mask;
        overlap  = |(taken_q & sel_mask);
        complete = &merged;
    end

    // Classify the request; empty takes precedence over a repeated lane.
    always_comb begin
        if (!req)
            outcome = OC_IDLE;
        else if (empty)
            outcome = OC_UNDER;
        else if (overlap)
            outcome = OC_DUP;
        else
            outcome = OC_DATA;
    end

    // Pop on the accepted read that fills the last lane.
    assign pop = (outcome == OC_DATA) && complete;

    // Update the taken-lane record: clear on pop, merge on accept, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            taken_q <= '0;
        else if (pop)
            taken_q <= '0;
        else if (outcome == OC_DATA)
            taken_q <= merged;
    end

    AST_POP_CLEARS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (taken_q == '0)); // R4

    AST_REFUSED_KEEPS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (empty || overlap)) |=> $stable(taken_q)); // R6

    AST_UNDER_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && empty) |=> $stable(taken_q)); // R7

    AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome == OC_DATA && !pop) |=> ($countones(taken_q) > $countones($past(taken_q)))); // R4

endmodule

// File: rtl/bur_read_formatter.sv
// Registers the bus response: valid, lane-placed data and the error flags.
// Assumes: the classification and lane mask are stable before the clock edge.
// Data lanes outside the selection, and all lanes on any error, read as zero.
module bur_read_formatter
    import byte_unstage_pkg::*;
#(
    parameter int WORD_BYTES = 8,
    parameter int BYTE_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  outcome_e                     outcome,
    input  logic [WORD_BYTES-1:0]        sel_mask,
    input  logic [WORD_BYTES*BYTE_W-1:0] head,
    output logic                         rd_valid,
    output logic [WORD_BYTES*BYTE_W-1:0] rd_data,
    output logic                         err_dup,
    output logic                         err_underflow
);

    localparam int DATA_W = WORD_BYTES * BYTE_W;

    logic [DATA_W-1:0] lanes_d;
    logic              accept;

    // Data is returned only for an accepted read.
    assign accept = (outcome == OC_DATA);

    // Gate each byte lane by its selection bit.
    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        assign lanes_d[i*BYTE_W +: BYTE_W] =
            (accept && sel_mask[i]) ? head[i*BYTE_W +: BYTE_W] : '0;
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid      <= 1'b0;
            rd_data       <= '0;
            err_dup       <= 1'b0;
            err_underflow <= 1'b0;
        end else begin
            rd_valid      <= (outcome != OC_IDLE);
            rd_data       <= lanes_d;
            err_dup       <= (outcome == OC_DUP);
            err_underflow <= (outcome == OC_UNDER);
        end
    end

    AST_ONE_ERROR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_dup && err_underflow)); // R6

    AST_ERROR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (err_dup || err_underflow) |-> (rd_data == '0)); // R7

    AST_ERROR_IS_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_dup || err_underflow) |-> rd_valid); // R6

    AST_QUIET_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0)); // R2

endmodule

// File: rtl/byte_unstage_reader.sv
// Top of the byte-granular output unstaging reader. Presents the head word of
// an output queue to a bus reading 1, 4 or 8 bytes, pops the queue once every
// lane has been read, and flags repeated lanes and reads of an empty queue.
// Assumes: first-word-fall-through queue; pop is sampled at the clock edge.
module byte_unstage_reader
    import byte_unstage_pkg::*;
#(
    parameter int WORD_BYTES = 8,
    parameter int MID_BYTES  = 4,
    parameter int BYTE_W     = 8,
    parameter int ADDR_W     = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [1:0]                   rd_size,
    input  logic                         fifo_empty,
    input  logic [WORD_BYTES*BYTE_W-1:0] fifo_head,
    output logic                         fifo_pop,
    output logic                         rd_valid,
    output logic [WORD_BYTES*BYTE_W-1:0] rd_data,
    output logic                         err_dup,
    output logic                         err_underflow
);

    logic [WORD_BYTES-1:0] sel_mask;
    outcome_e              outcome;

    bur_lane_decode #(
        .WORD_BYTES (WORD_BYTES),
        .MID_BYTES  (MID_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .addr     (rd_addr),
        .size     (rd_size),
        .sel_mask (sel_mask)
    );

    bur_consume_tracker #(
        .WORD_BYTES (WORD_BYTES)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rd_en),
        .empty    (fifo_empty),
        .sel_mask (sel_mask),
        .outcome  (outcome),
        .pop      (fifo_pop)
    );

    bur_read_formatter #(
        .WORD_BYTES (WORD_BYTES),
        .BYTE_W     (BYTE_W)
    ) u_format (
        .clk           (clk),
        .rst_n         (rst_n),
        .outcome       (outcome),
        .sel_mask      (sel_mask),
        .head          (fifo_head),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .err_dup       (err_dup),
        .err_underflow (err_underflow)
    );

    AST_POP_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (rd_en && !fifo_empty)); // R8

    AST_REQUEST_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R2

    AST_NO_REQUEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && !err_dup && !err_underflow)); // R8

    AST_UNDERFLOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fifo_empty) |=> err_underflow); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !err_dup && !err_underflow)); // R1

endmodule

// File: tb/byte_unstage_reader_test.sv
module byte_unstage_reader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [1:0]  rd_size = '0;
    logic        fifo_empty = 1'b1;
    logic [63:0] fifo_head = '0;
    logic        fifo_pop;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        err_dup;
    logic        err_underflow;

    always #5 clk = ~clk;

    byte_unstage_reader uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_size(rd_size), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
        .fifo_pop(fifo_pop), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_dup(err_dup), .err_underflow(err_underflow)
    );

    int checks = 0;
    int errors = 0;

    // Bench-side queue and taken-lane model
    logic [63:0] q[$];
    logic [7:0]  m_taken = '0;
    // Expectations for the response visible after the next edge
    logic        e_valid = 0, e_dup = 0, e_under = 0;
    logic [63:0] e_data = '0;
    string       e_req = "R8";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] lane_mask(input logic [11:0] a, input logic [1:0] s);
        if (s == 2'd0) return 8'd1 << a[2:0];
        if (s == 2'd1) return a[2] ? 8'hF0 : 8'h0F;
        return 8'hFF;
    endfunction

    function automatic logic [63:0] place(input logic [63:0] w, input logic [7:0] m);
        logic [63:0] r = '0;
        for (int i = 0; i < 8; i++) if (m[i]) r[i*8 +: 8] = w[i*8 +: 8];
        return r;
    endfunction

    function automatic void refresh();
        fifo_empty = (q.size() == 0);
        fifo_head  = (q.size() != 0) ? q[0] : 64'd0;
    endfunction

    // Check the pending response, then optionally present one request.
    task automatic step(input bit en, input logic [11:0] a, input logic [1:0] s, input string req);
        logic [7:0] m;
        bit under, dup, done;
        @(negedge clk);
        chk(rd_valid == e_valid, e_req, "rd_valid", 64'(rd_valid), 64'(e_valid));
        chk(rd_data == e_data, e_req, "rd_data", rd_data, e_data);
        chk(err_dup == e_dup, "R6", "err_dup", 64'(err_dup), 64'(e_dup));
        chk(err_underflow == e_under, "R7", "err_underflow", 64'(err_underflow), 64'(e_under));
        rd_en = en; rd_addr = a; rd_size = s;
        m = lane_mask(a, s);
        under = en && (q.size() == 0);
        dup = en && !under && ((m & m_taken) != 0);
        done = en && !under && !dup && ((m | m_taken) == 8'hFF);
        #1;
        chk(fifo_pop == done, (req == "") ? "R4" : req, "fifo_pop", 64'(fifo_pop), 64'(done));
        e_valid = en; e_dup = dup; e_under = under;
        e_data = (en && !under && !dup) ? place(q[0], m) : 64'd0;
        e_req = (req == "") ? "R2" : req;
        @(posedge clk);
        #1;
        if (done) begin
            void'(q.pop_front());
            m_taken = '0;
        end else if (en && !under && !dup) begin
            m_taken = m_taken | m;
        end
        refresh();
    endtask

    task automatic push(input logic [63:0] w);
        q.push_back(w);
        refresh();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        refresh();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet during reset
        chk(rd_valid == 0 && err_dup == 0 && err_underflow == 0, "R1", "flags in reset",
            {61'd0, rd_valid, err_dup, err_underflow}, 64'd0);
        chk(rd_data == 0, "R1", "rd_data in reset", rd_data, 64'd0);
        rst_n = 1'b1;
        step(0, 0, 0, "R1");

        // R7: read of empty queue
        step(1, 12'h010, 2'd0, "R7");
        step(0, 0, 0, "R7");
        // R5: whole-word read of fresh word pops in the request cycle
        push(64'h1122_3344_5566_7788);
        push(64'hA1B2_C3D4_E5F6_0718);
        step(1, 12'h000, 2'd2, "R5");
        // R3: single bytes in reverse order with high address bits set, back to back
        for (int i = 7; i >= 0; i--) step(1, 12'hF00 | 12'(i), 2'd0, "R3");
        step(0, 0, 0, "R3");
        // R6: repeat of a taken lane, then completion still pops on the right read
        push(64'h0102_0304_0506_0708);
        step(1, 12'h004, 2'd1, "R3");
        step(1, 12'h006, 2'd0, "R6");
        step(1, 12'h000, 2'd2, "R6");
        step(1, 12'h003, 2'd1, "R4");
        // R9: spare width code reads the whole word
        push(64'hDEAD_BEEF_CAFE_F00D);
        step(1, 12'h7A5, 2'd3, "R9");
        step(1, 12'h000, 2'd0, "R7");
        step(0, 0, 0, "R8");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] sz;
            int r = int'($urandom_range(0, 9));
            if (($urandom_range(0, 3) == 0) && q.size() < 4)
                push({$urandom(), $urandom()});
            sz = (r < 6) ? 2'd0 : (r < 9) ? 2'd1 : 2'(2 + $urandom_range(0, 1));
            step($urandom_range(0, 3) != 0, 12'($urandom()), sz, "");
        end
        step(0, 0, 0, "R8");
        step(0, 0, 0, "R8");

        // Reset mid-word clears the record: R1
        push(64'h5555_6666_7777_8888);
        step(1, 12'h000, 2'd0, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_taken = '0; e_valid = 0; e_dup = 0; e_under = 0; e_data = '0; e_req = "R1";
        step(1, 12'h000, 2'd0, "R1");
        step(0, 0, 0, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule